// File: doc/BRIEF.md
# Compressed Sensing Readout Sequencer

This block is the digital sequencer behind a column multiplexer that feeds per-column sigma-delta converters. The pixel array is split into square 16x16 tiles. For each tile, every converter in the tile's lane set builds up one random binary combination of the tile's pixels. On every sample cycle the block drives these outputs: a one-hot column pick for each column selector, one apply-or-reference bit for each converter, the pixel row inside the tile, the tile row, the tile group and its first tile, and a flag that tells the reset pass from the signal pass.

A frame starts with a one-cycle `start` pulse that carries a 2-bit compression mode. The sequencer reads each group of tiles twice. The first pass samples the reset level and the second samples the signal level, and both use exactly the same pattern, so correlated double sampling can be done digitally afterwards. It moves through the groups of a tile row, then on to the next tile row, until the frame is done. The random bits come from a bank of 16-bit linear feedback shift registers. These are reloaded with fixed seeds at the start of every pass.

Top module: `cs_readout_seq`

## Requirements
- R1: After reset, and whenever no frame is running, `busy`, `sample_valid`, `bypass`, `phase_sig`, `adc_start`, `adc_done`, `frame_done`, `col_sel`, `adc_apply`, `pix_row`, `grp_idx`, `blk_base` and `blk_row` are all zero.
- R2: The mode encoding is 00 = ratio 1 (direct readout), 01 = 1/4, 10 = 1/8, 11 = 1/16. A group holds 4, 8 or 16 tiles in modes 01, 10 and 11, and all 16 tiles of the row in mode 00. Tile groups per row are therefore 4, 2, 1 and 1. `blk_base` equals `grp_idx` times the group size.
- R3: Each group is read in two passes, first with `phase_sig`=0 (reset) and then with `phase_sig`=1 (signal). A pass has 128 sample cycles: 16 pixel rows in ascending order, with 8 selections per row. One non-sample gap cycle follows each pass.
- R4: During selection c (0..7) of a row, selector k (0..3) has only bit (2c+k) mod 16 of its 16-bit field `col_sel[16k+15:16k]` set. Outside sample cycles `col_sel` is zero.
- R5: Each generator j (0..1) is a right-shifting 16-bit register. On every sample cycle it shifts right by one, and if the bit shifted out was 1 the new value is XORed with 0xB400. At the start of each pass it is loaded with 0xACE1 XOR (0x3C5B times j), truncated to 16 bits. In a sample cycle, `adc_apply[i]` equals bit i/2 of generator i mod 2, taken before that cycle's shift.
- R6: The signal pass of a group drives exactly the same `adc_apply` sequence as its reset pass.
- R7: In mode 00, `bypass` is 1 for the whole frame and `adc_apply` stays zero. In all other modes `bypass` is 0.
- R8: `adc_start` is high on the first sample cycle of each pass only. `adc_done` is high on the gap cycle after the 128th sample only.
- R9: Groups advance within a tile row, and then tile rows advance from 0 to 15. `frame_done` is high together with the last `adc_done`, and the block is idle on the next cycle.
- R10: A `start` pulse while a frame runs is ignored. The running frame keeps its mode and its sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Frame start pulse, accepted only when idle |
| cr_mode | input | 2 | Compression mode, captured with `start` |
| busy | output | 1 | A frame is in progress |
| bypass | output | 1 | Direct readout frame (ratio 1) |
| sample_valid | output | 1 | Current cycle is a sample cycle |
| phase_sig | output | 1 | 0 = reset pass, 1 = signal pass |
| blk_row | output | 4 | Tile row index |
| grp_idx | output | 4 | Tile group index within the row |
| blk_base | output | 4 | First tile of the current group |
| pix_row | output | 4 | Pixel row within the tile |
| col_sel | output | 64 | One-hot column codes, 16 bits per selector |
| adc_apply | output | 16 | Per-converter pixel (1) or reference (0) select |
| adc_start | output | 1 | First sample of a pass |
| adc_done | output | 1 | Pass complete |
| frame_done | output | 1 | Last pass of the frame complete |

## Verification
Some properties are checked by assertions on every cycle. These cover: one set bit per selector in sample cycles and none between them, apply bits held low in direct readout, `adc_start` only on pixel row 0, `adc_done` only right after a sample cycle, phase and group changes only after a gap cycle, a constant mode during a frame, and idling after `frame_done`. Other behaviour depends on a full reference sequence, and only the bench scenarios show it. This includes the exact selector bit positions, the pseudo-random apply values, the reseeding that makes the two passes equal, the group count and base for each mode, the row-then-group-then-tile-row ordering with the frame length, and the rejection of a mid-frame `start`.

// File: rtl/csq_pkg.sv
package csq_pkg;

   typedef enum logic [1:0] {
      CR_FULL      = 2'd0,
      CR_QUARTER   = 2'd1,
      CR_EIGHTH    = 2'd2,
      CR_SIXTEENTH = 2'd3
   } cr_mode_e;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_RUN  = 2'd1,
      ST_GAP  = 2'd2
   } seq_state_e;

   localparam logic [15:0] PRNG_TAPS = 16'hB400;

   function automatic logic [15:0] prng_next(input logic [15:0] s);
      logic [15:0] n;
      n = s >> 1;
      if (s[0]) n = n ^ PRNG_TAPS;
      return n;
   endfunction

   function automatic logic [15:0] prng_seed(input logic [15:0] base,
                                             input logic [15:0] step,
                                             input int          idx);
      logic [15:0] p;
      logic [15:0] v;
      p = step * 16'(idx);
      v = base ^ p;
      return (v == 16'h0) ? 16'h0001 : v;
   endfunction

endpackage

// File: rtl/cs_mode_decode.sv
module cs_mode_decode
   import csq_pkg::*;
#(
   parameter int NBLK_PER_ROW = 16,
   localparam int GRP_W = $clog2(NBLK_PER_ROW),
   localparam int LOG_W = $clog2(GRP_W + 1)
) (
   input  cr_mode_e             mode,
   output logic                 dec_bypass,
   output logic [GRP_W-1:0]     grp_last,
   output logic [LOG_W-1:0]     grp_log2
);

   if (NBLK_PER_ROW < 16 || (NBLK_PER_ROW & (NBLK_PER_ROW - 1)) != 0) begin : g_bad_nblk
      $error("NBLK_PER_ROW must be a power of two of at least 16");
   end

   int lg;

   always_comb begin
      dec_bypass = 1'b0;
      case (mode)
         CR_QUARTER:   lg = 2;
         CR_EIGHTH:    lg = 3;
         CR_SIXTEENTH: lg = 4;
         default: begin
            lg         = GRP_W;
            dec_bypass = 1'b1;
         end
      endcase
      grp_log2 = LOG_W'(lg);
      grp_last = GRP_W'((NBLK_PER_ROW >> lg) - 1);
   end

endmodule

// File: rtl/cs_seq_ctrl.sv
module cs_seq_ctrl
   import csq_pkg::*;
#(
   parameter int ROWS    = 16,
   parameter int SELS    = 8,
   parameter int GRP_W   = 4,
   parameter int NBROWS  = 16,
   localparam int ROW_W  = $clog2(ROWS),
   localparam int COL_W  = $clog2(SELS),
   localparam int BROW_W = $clog2(NBROWS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [GRP_W-1:0]  grp_last,
   output logic              busy,
   output logic              sample_valid,
   output logic              phase_sig,
   output logic              adc_start,
   output logic              adc_done,
   output logic              frame_done,
   output logic              seed_load,
   output logic              mode_load,
   output logic [COL_W-1:0]  col,
   output logic [ROW_W-1:0]  row,
   output logic [GRP_W-1:0]  grp,
   output logic [BROW_W-1:0] brow
);

   if (ROWS < 2 || SELS < 2 || NBROWS < 2) begin : g_bad_dims
      $error("sequencer dimensions must be at least 2");
   end

   localparam logic [COL_W-1:0]  COL_LAST  = COL_W'(SELS - 1);
   localparam logic [ROW_W-1:0]  ROW_LAST  = ROW_W'(ROWS - 1);
   localparam logic [BROW_W-1:0] BROW_LAST = BROW_W'(NBROWS - 1);

   seq_state_e st;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st        <= ST_IDLE;
         col       <= '0;
         row       <= '0;
         grp       <= '0;
         brow      <= '0;
         phase_sig <= 1'b0;
      end else begin
         case (st)
            ST_IDLE: begin
               if (start) begin
                  st        <= ST_RUN;
                  col       <= '0;
                  row       <= '0;
                  grp       <= '0;
                  brow      <= '0;
                  phase_sig <= 1'b0;
               end
            end
            ST_RUN: begin
               if (col == COL_LAST) begin
                  col <= '0;
                  if (row == ROW_LAST) begin
                     row <= '0;
                     st  <= ST_GAP;
                  end else begin
                     row <= row + 1'b1;
                  end
               end else begin
                  col <= col + 1'b1;
               end
            end
            ST_GAP: begin
               if (!phase_sig) begin
                  phase_sig <= 1'b1;
                  st        <= ST_RUN;
               end else begin
                  phase_sig <= 1'b0;
                  if (grp == grp_last) begin
                     grp <= '0;
                     if (brow == BROW_LAST) begin
                        brow <= '0;
                        st   <= ST_IDLE;
                     end else begin
                        brow <= brow + 1'b1;
                        st   <= ST_RUN;
                     end
                  end else begin
                     grp <= grp + 1'b1;
                     st  <= ST_RUN;
                  end
               end
            end
            default: st <= ST_IDLE;
         endcase
      end
   end

   always_comb begin
      busy         = (st != ST_IDLE);
      sample_valid = (st == ST_RUN);
      adc_start    = (st == ST_RUN) && (row == '0) && (col == '0);
      adc_done     = (st == ST_GAP);
      frame_done   = (st == ST_GAP) && phase_sig && (grp == grp_last) && (brow == BROW_LAST);
      mode_load    = (st == ST_IDLE) && start;
      seed_load    = mode_load || (st == ST_GAP);
   end

endmodule

// File: rtl/cs_col_rotator.sv
module cs_col_rotator #(
   parameter int NSEL     = 4,
   parameter int BLK_W    = 16,
   parameter int SELS     = 8,
   parameter int ROT_STEP = 1,
   localparam int COL_W   = $clog2(SELS),
   localparam int POS_W   = $clog2(BLK_W),
   localparam int STRIDE  = BLK_W / SELS
) (
   input  logic                    valid,
   input  logic [COL_W-1:0]        col,
   output logic [NSEL*BLK_W-1:0]   sel
);

   if ((BLK_W & (BLK_W - 1)) != 0 || (BLK_W % SELS) != 0) begin : g_bad_width
      $error("BLK_W must be a power of two and a multiple of SELS");
   end

   for (genvar k = 0; k < NSEL; k++) begin : g_sel
      logic [POS_W-1:0] pos;
      logic [BLK_W-1:0] code;
      always_comb begin
         pos  = POS_W'(int'(col) * STRIDE + k * ROT_STEP);
         code = valid ? (BLK_W'(1) << pos) : '0;
      end
      assign sel[k*BLK_W +: BLK_W] = code;
   end

endmodule

// File: rtl/cs_prng_bank.sv
module cs_prng_bank
   import csq_pkg::*;
#(
   parameter int          NADC      = 16,
   parameter int          NLFSR     = 2,
   parameter logic [15:0] SEED_BASE = 16'hACE1,
   parameter logic [15:0] SEED_STEP = 16'h3C5B
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            load,
   input  logic            step,
   output logic [NADC-1:0] bits
);

   if (NLFSR < 1 || NADC > 16 * NLFSR) begin : g_bad_bank
      $error("NADC must not exceed 16 bits per generator");
   end

   logic [15:0] gen_q [NLFSR];

   for (genvar j = 0; j < NLFSR; j++) begin : g_gen
      localparam logic [15:0] SEED_J = prng_seed(SEED_BASE, SEED_STEP, j);
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)      gen_q[j] <= SEED_J;
         else if (load)   gen_q[j] <= SEED_J;
         else if (step)   gen_q[j] <= prng_next(gen_q[j]);
      end
   end

   for (genvar i = 0; i < NADC; i++) begin : g_tap
      assign bits[i] = gen_q[i % NLFSR][i / NLFSR];
   end

endmodule

// File: rtl/cs_readout_seq.sv
module cs_readout_seq
   import csq_pkg::*;
#(
   parameter int          NBLK_PER_ROW = 16,
   parameter int          NBLK_ROWS    = 16,
   parameter int          BLK_DIM      = 16,
   parameter int          SELS_PER_ROW = 8,
   parameter int          NSEL         = 4,
   parameter int          NADC         = 16,
   parameter int          NLFSR        = 2,
   parameter int          ROT_STEP     = 1,
   parameter logic [15:0] SEED_BASE    = 16'hACE1,
   parameter logic [15:0] SEED_STEP    = 16'h3C5B,
   localparam int GRP_W  = $clog2(NBLK_PER_ROW),
   localparam int BROW_W = $clog2(NBLK_ROWS),
   localparam int ROW_W  = $clog2(BLK_DIM)
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    start,
   input  logic [1:0]              cr_mode,
   output logic                    busy,
   output logic                    bypass,
   output logic                    sample_valid,
   output logic                    phase_sig,
   output logic [BROW_W-1:0]       blk_row,
   output logic [GRP_W-1:0]        grp_idx,
   output logic [GRP_W-1:0]        blk_base,
   output logic [ROW_W-1:0]        pix_row,
   output logic [NSEL*BLK_DIM-1:0] col_sel,
   output logic [NADC-1:0]         adc_apply,
   output logic                    adc_start,
   output logic                    adc_done,
   output logic                    frame_done
);

   localparam int COL_W = $clog2(SELS_PER_ROW);
   localparam int LOG_W = $clog2(GRP_W + 1);

   cr_mode_e           mode_q;
   logic               mode_load;
   logic               seed_load;
   logic               dec_bypass;
   logic [GRP_W-1:0]   grp_last;
   logic [LOG_W-1:0]   grp_log2;
   logic [COL_W-1:0]   col;
   logic [NADC-1:0]    prng_bits;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         mode_q <= CR_FULL;
      else if (mode_load) mode_q <= cr_mode_e'(cr_mode);
   end

   cs_mode_decode #(.NBLK_PER_ROW(NBLK_PER_ROW)) dec_i (
      .mode       (mode_q),
      .dec_bypass (dec_bypass),
      .grp_last   (grp_last),
      .grp_log2   (grp_log2)
   );

   cs_seq_ctrl #(
      .ROWS   (BLK_DIM),
      .SELS   (SELS_PER_ROW),
      .GRP_W  (GRP_W),
      .NBROWS (NBLK_ROWS)
   ) ctrl_i (
      .clk          (clk),
      .rst_n        (rst_n),
      .start        (start),
      .grp_last     (grp_last),
      .busy         (busy),
      .sample_valid (sample_valid),
      .phase_sig    (phase_sig),
      .adc_start    (adc_start),
      .adc_done     (adc_done),
      .frame_done   (frame_done),
      .seed_load    (seed_load),
      .mode_load    (mode_load),
      .col          (col),
      .row          (pix_row),
      .grp          (grp_idx),
      .brow         (blk_row)
   );

   cs_col_rotator #(
      .NSEL     (NSEL),
      .BLK_W    (BLK_DIM),
      .SELS     (SELS_PER_ROW),
      .ROT_STEP (ROT_STEP)
   ) rot_i (
      .valid (sample_valid),
      .col   (col),
      .sel   (col_sel)
   );

   cs_prng_bank #(
      .NADC      (NADC),
      .NLFSR     (NLFSR),
      .SEED_BASE (SEED_BASE),
      .SEED_STEP (SEED_STEP)
   ) prng_i (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (seed_load),
      .step  (sample_valid),
      .bits  (prng_bits)
   );

   always_comb begin
      bypass    = busy && dec_bypass;
      blk_base  = GRP_W'(grp_idx << grp_log2);
      adc_apply = (sample_valid && !dec_bypass) ? prng_bits : '0;
   end

endmodule

// File: rtl/cs_readout_seq_chk.sv
module cs_readout_seq_chk #(
   parameter int NSEL    = 4,
   parameter int BLK_DIM = 16,
   parameter int NADC    = 16,
   parameter int GRP_W   = 4,
   parameter int BROW_W  = 4,
   parameter int ROW_W   = 4
) (
   input logic                    clk,
   input logic                    rst_n,
   input logic                    busy,
   input logic                    bypass,
   input logic                    sample_valid,
   input logic                    phase_sig,
   input logic [GRP_W-1:0]        grp_idx,
   input logic [ROW_W-1:0]        pix_row,
   input logic [NSEL*BLK_DIM-1:0] col_sel,
   input logic [NADC-1:0]         adc_apply,
   input logic                    adc_start,
   input logic                    adc_done,
   input logic                    frame_done
);

   for (genvar k = 0; k < NSEL; k++) begin : g_onehot
      // R4: exactly one column per selector during sampling
      a_r4_sel_single_bit: assert property (@(posedge clk) disable iff (!rst_n)
         sample_valid |-> ($countones(col_sel[k*BLK_DIM +: BLK_DIM]) == 1));
   end

   a_r4_sel_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
      !sample_valid |-> (col_sel == '0));

   a_r7_bypass_no_apply: assert property (@(posedge clk) disable iff (!rst_n)
      bypass |-> (adc_apply == '0));

   a_r8_start_row0: assert property (@(posedge clk) disable iff (!rst_n)
      adc_start |-> (sample_valid && pix_row == '0));

   a_r8_done_after_sample: assert property (@(posedge clk) disable iff (!rst_n)
      adc_done |-> ($past(sample_valid) && !sample_valid));

   a_r3_phase_flip_at_gap: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(phase_sig) |-> $past(adc_done));

   a_r9_grp_moves_after_signal: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(grp_idx) |-> ($past(adc_done) && $past(phase_sig)));

   a_r10_mode_held: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy)) |-> $stable(bypass));

   a_r9_frame_end_idle: assert property (@(posedge clk) disable iff (!rst_n)
      frame_done |=> !busy);

endmodule

bind cs_readout_seq cs_readout_seq_chk #(
   .NSEL    (NSEL),
   .BLK_DIM (BLK_DIM),
   .NADC    (NADC),
   .GRP_W   (GRP_W),
   .BROW_W  (BROW_W),
   .ROW_W   (ROW_W)
) chk_i (
   .clk          (clk),
   .rst_n        (rst_n),
   .busy         (busy),
   .bypass       (bypass),
   .sample_valid (sample_valid),
   .phase_sig    (phase_sig),
   .grp_idx      (grp_idx),
   .pix_row      (pix_row),
   .col_sel      (col_sel),
   .adc_apply    (adc_apply),
   .adc_start    (adc_start),
   .adc_done     (adc_done),
   .frame_done   (frame_done)
);

// File: tb/cs_readout_seq_tb_top.sv
module cs_readout_seq_tb_top;

   localparam int NSEL  = 4;
   localparam int BLK   = 16;
   localparam int SELS  = 8;
   localparam int NADC  = 16;
   localparam int NLFSR = 2;
   localparam int NBR   = 16;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [1:0]  cr_mode = 2'b00;
   logic        busy, bypass, sample_valid, phase_sig;
   logic [3:0]  blk_row, grp_idx, blk_base, pix_row;
   logic [63:0] col_sel;
   logic [15:0] adc_apply;
   logic        adc_start, adc_done, frame_done;

   int checks = 0;
   int errors = 0;

   always #10 clk = ~clk;

   cs_readout_seq dut_i (
      .clk(clk), .rst_n(rst_n), .start(start), .cr_mode(cr_mode),
      .busy(busy), .bypass(bypass), .sample_valid(sample_valid), .phase_sig(phase_sig),
      .blk_row(blk_row), .grp_idx(grp_idx), .blk_base(blk_base), .pix_row(pix_row),
      .col_sel(col_sel), .adc_apply(adc_apply), .adc_start(adc_start),
      .adc_done(adc_done), .frame_done(frame_done)
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   function automatic logic [15:0] nxt(input logic [15:0] s);
      logic [15:0] n;
      n = s >> 1;
      if (s[0]) n = n ^ 16'hB400;
      return n;
   endfunction

   function automatic logic [15:0] seed_of(input int j);
      logic [15:0] v;
      v = 16'hACE1 ^ 16'(16'h3C5B * 16'(j));
      return (v == 0) ? 16'h1 : v;
   endfunction

   task automatic check_idle(input string req);
      chk(busy == 0 && sample_valid == 0 && bypass == 0 && phase_sig == 0, req, "flags",
          {busy, sample_valid, bypass, phase_sig}, 0);
      chk(adc_start == 0 && adc_done == 0 && frame_done == 0, req, "pulses",
          {adc_start, adc_done, frame_done}, 0);
      chk(col_sel == 0 && adc_apply == 0, req, "sel/apply", {col_sel[47:0], adc_apply}, 0);
      chk({blk_row, grp_idx, blk_base, pix_row} == 0, req, "indices",
          {blk_row, grp_idx, blk_base, pix_row}, 0);
   endtask

   // R1: reset state
   task automatic test_reset;
      rst_n = 1'b0;
      start = 1'b0;
      repeat (3) @(negedge clk);
      check_idle("R1");
      rst_n = 1'b1;
      @(negedge clk);
      check_idle("R1");
   endtask

   // Full-frame model: R2 R3 R4 R5 R6 R7 R8 R9 (and R10 when poke=1)
   task automatic run_frame(input logic [1:0] mode, input bit poke);
      int groups;
      int gsize;
      logic [15:0] lf [NLFSR];
      logic [63:0] esel;
      logic [15:0] eapp;
      string tg;
      groups = (mode == 2'd1) ? 4 : (mode == 2'd2) ? 2 : 1;
      gsize  = (mode == 2'd1) ? 4 : (mode == 2'd2) ? 8 : 16;
      tg     = poke ? "R10" : "R2";
      cr_mode = mode;
      start   = 1'b1;
      @(negedge clk);
      start   = 1'b0;
      cr_mode = ~mode;
      for (int br = 0; br < NBR; br++) begin
         for (int g = 0; g < groups; g++) begin
            for (int ph = 0; ph < 2; ph++) begin
               for (int j = 0; j < NLFSR; j++) lf[j] = seed_of(j);
               for (int r = 0; r < BLK; r++) begin
                  for (int c = 0; c < SELS; c++) begin
                     esel = '0;
                     for (int k = 0; k < NSEL; k++) esel[k*BLK + ((2*c + k) % BLK)] = 1'b1;
                     eapp = '0;
                     if (mode != 2'd0)
                        for (int i = 0; i < NADC; i++) eapp[i] = lf[i % NLFSR][i / NLFSR];
                     chk(sample_valid == 1 && busy == 1 && adc_done == 0, "R3", "valid",
                         {busy, sample_valid, adc_done}, 3'b110);
                     chk(pix_row == 4'(r) && phase_sig == ph[0], "R3", "row/phase",
                         {phase_sig, pix_row}, {ph[0], 4'(r)});
                     chk(col_sel == esel, "R4", "col_sel", col_sel, esel);
                     chk(adc_apply == eapp, (mode == 2'd0) ? "R7" : (ph == 1 ? "R6" : "R5"),
                         "apply", adc_apply, eapp);
                     chk(bypass == (mode == 2'd0), "R7", "bypass", bypass, (mode == 2'd0));
                     chk(grp_idx == 4'(g) && blk_base == 4'(g * gsize), tg, "grp/base",
                         {grp_idx, blk_base}, {4'(g), 4'(g * gsize)});
                     chk(blk_row == 4'(br), "R9", "blk_row", blk_row, br);
                     chk(adc_start == (r == 0 && c == 0), "R8", "adc_start", adc_start,
                         (r == 0 && c == 0));
                     for (int j = 0; j < NLFSR; j++) lf[j] = nxt(lf[j]);
                     start = (poke && br == 1 && g == 0 && ph == 0 && r == 3 && c == 2);
                     if (start) cr_mode = (mode == 2'd0) ? 2'd1 : 2'd0;
                     @(negedge clk);
                  end
               end
               start = 1'b0;
               chk(adc_done == 1 && sample_valid == 0 && col_sel == 0, "R8", "gap",
                   {adc_done, sample_valid}, 2'b10);
               chk(frame_done == (br == NBR - 1 && g == groups - 1 && ph == 1), "R9",
                   "frame_done", frame_done, (br == NBR - 1 && g == groups - 1 && ph == 1));
               @(negedge clk);
            end
         end
      end
      chk(busy == 0, "R9", "idle after frame", busy, 0);
      check_idle("R1");
   endtask

   initial begin
      test_reset();
      run_frame(2'd1, 1'b0);
      run_frame(2'd2, 1'b0);
      run_frame(2'd3, 1'b0);
      run_frame(2'd0, 1'b0);
      run_frame(2'd3, 1'b1);
      run_frame(2'd0, 1'b1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule